// File: doc/BRIEF.md
# Thread Interrupt Presenter

This block sits between the event-queue writer and one hardware thread. The queue writer signals, one priority at a time, that work has been posted at some priority level. The presenter remembers which levels hold pending work and keeps the thread's current priority (its masking threshold). It raises the interrupt line whenever pending work is more urgent than that threshold. Urgency runs downward: a smaller priority number is more urgent.

Software reaches the presenter through a small register port. A byte-wide threshold register can be written and read back. A 16-bit accept register has a side effect when read: it takes the most urgent pending level, clears it, and raises the threshold to that level. The read returns a two-bit event-type code together with the accepted level. After servicing, software writes its earlier threshold back. It may keep reading the accept register until the type code reads as "nothing".

Top module: `thread_irq_presenter`

## Requirements
- R1: After reset the threshold is 0x00, no level is pending, `irq` is low and `rd_valid` is low.
- R2: A cycle with `ev_valid` high marks level `ev_prio` (0 to 7) pending from the next cycle on. Marks from several cycles accumulate.
- R3: `irq` is high exactly when some pending level number is strictly smaller than the threshold. A threshold of 0xFF masks nothing, and a pending level equal to the threshold is not presented.
- R4: A write at offset 0x031 loads `wr_data` into the threshold at the next clock edge. A read at 0x031 returns {8'h00, threshold}.
- R5: A read at offset 0x830 while an interrupt is presented returns bits 15:14 = 2'b10 (physical event), bits 13:8 = 0, and the low byte = the smallest pending level number.
- R6: That accepting read loads the accepted level into the threshold and clears its pending mark. The presentation then depends only on the remaining marks against the new threshold.
- R7: A read at 0x830 while nothing is presented returns bits 15:14 = 2'b00 with the current threshold in the low byte, and changes neither the threshold nor any pending mark.
- R8: A notification arriving in the same cycle as an accepting read stays pending, including when it names the level being accepted.
- R9: Read data appears on `rd_data` with `rd_valid` high in the cycle after the request. Reads at other offsets return 0. Writes at any offset other than 0x031 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Notification from the event-queue writer |
| ev_prio | input | 3 | Priority level of the notification |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Register byte offset |
| wr_data | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 16 | Read data |
| irq | output | 1 | Interrupt request to the thread |

## Verification
The hardest case to reach from the ports is a notification that lands in the very cycle an accept read consumes the same level. The clear and the set then meet on one flag. The bench drives the notification and the accept read on one falling edge. It then raises the threshold again and shows that a second accept returns the same level. The main sweep covers every one of the 256 pending patterns against thresholds 0 to 8 and 0xFF. Each pattern is rebuilt from an empty state by draining through repeated accepts.

// File: rtl/ipr_pkg.sv
// Package: shared encodings for the thread interrupt presenter.
// Assumes a fixed 16-bit accept word with the type code in bits 15:14.
package ipr_pkg;
    typedef enum logic [1:0] {
        EXC_NONE = 2'b00,
        EXC_PHYS = 2'b10
    } exc_type_e;

    localparam int ACK_W  = 16;
    localparam int CPPR_W = 8;
endpackage

// File: rtl/ipr_pending.sv
// Module: one sticky pending flag per priority level.
// Assumes set and clear indices are in range; a set wins over a clear of the same level.
module ipr_pending #(
    parameter int NUM_PRIO = 8,
    localparam int PRIO_W  = $clog2(NUM_PRIO)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [PRIO_W-1:0]   set_idx,
    input  logic                clr_en,
    input  logic [PRIO_W-1:0]   clr_idx,
    output logic [NUM_PRIO-1:0] pend
);
    for (genvar g = 0; g < NUM_PRIO; g++) begin : g_flag
        // Per-level flag: set by a notification, cleared by acceptance, set first.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[g] <= 1'b0;
            else if (set_en && set_idx == PRIO_W'(g))
                pend[g] <= 1'b1;
            else if (clr_en && clr_idx == PRIO_W'(g))
                pend[g] <= 1'b0;
        end
    end

    a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> pend[$past(set_idx)]);
    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && clr_en && set_idx == clr_idx) |=> pend[$past(clr_idx)]);
endmodule

// File: rtl/ipr_pick.sv
// Module: finds the most urgent (lowest-numbered) pending level.
// Assumes a pure combinational use; best is 0 when nothing is pending.
module ipr_pick #(
    parameter int NUM_PRIO = 8,
    localparam int PRIO_W  = $clog2(NUM_PRIO)
) (
    input  logic [NUM_PRIO-1:0] pend,
    output logic                any,
    output logic [PRIO_W-1:0]   best
);
    // Scan from least to most urgent so the lowest set index is kept last.
    always_comb begin
        best = '0;
        for (int i = NUM_PRIO - 1; i >= 0; i--) begin
            if (pend[i])
                best = PRIO_W'(i);
        end
        any = |pend;
    end
endmodule

// File: rtl/ipr_cppr.sv
// Module: the thread's current priority (threshold) register.
// Assumes acceptance and a software write never coincide (one request per cycle).
module ipr_cppr #(
    parameter int PRIO_W = 3,
    parameter int CPPR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CPPR_W-1:0] wr_val,
    input  logic              take,
    input  logic [PRIO_W-1:0] take_prio,
    output logic [CPPR_W-1:0] cppr
);
    // Threshold update: acceptance raises it, a software write replaces it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cppr <= '0;
        else if (take)
            cppr <= CPPR_W'(take_prio);
        else if (wr_en)
            cppr <= wr_val;
    end

    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !take) |=> cppr == $past(wr_val));
endmodule

// File: rtl/thread_irq_presenter.sv
// Module: per-thread interrupt presenter with a priority threshold and a
// side-effecting accept register. Assumes one register request per cycle and
// NUM_PRIO levels numbered so that lower means more urgent.
module thread_irq_presenter
    import ipr_pkg::*;
#(
    parameter int NUM_PRIO = 8,
    parameter int ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] CPPR_OFF = 12'h031,
    parameter logic [ADDR_W-1:0] ACK_OFF  = 12'h830,
    localparam int PRIO_W  = $clog2(NUM_PRIO)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [PRIO_W-1:0] ev_prio,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic              irq
);
    logic [NUM_PRIO-1:0] pend;
    logic                any_pend;
    logic [PRIO_W-1:0]   best;
    logic [CPPR_W-1:0]   cppr_q;
    logic                is_rd, rd_ack, rd_cppr, wr_cppr, present, take;

    // Request decode.
    always_comb begin
        is_rd   = req_valid && !req_write;
        rd_ack  = is_rd && req_addr == ACK_OFF;
        rd_cppr = is_rd && req_addr == CPPR_OFF;
        wr_cppr = req_valid && req_write && req_addr == CPPR_OFF;
    end

    // Presentation: most urgent pending level strictly beats the threshold.
    always_comb begin
        present = any_pend && (CPPR_W'(best) < cppr_q);
        take    = rd_ack && present;
        irq     = present;
    end

    ipr_pending #(.NUM_PRIO(NUM_PRIO)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .set_en(ev_valid), .set_idx(ev_prio),
        .clr_en(take), .clr_idx(best),
        .pend(pend)
    );

    ipr_pick #(.NUM_PRIO(NUM_PRIO)) u_pick (
        .pend(pend), .any(any_pend), .best(best)
    );

    ipr_cppr #(.PRIO_W(PRIO_W), .CPPR_W(CPPR_W)) u_cppr (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_cppr), .wr_val(wr_data),
        .take(take), .take_prio(best),
        .cppr(cppr_q)
    );

    // Read return path, registered one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= is_rd;
            if (take)
                rd_data <= {EXC_PHYS, 6'b0, 8'(best)};
            else if (rd_ack || rd_cppr)
                rd_data <= {EXC_NONE, 6'b0, cppr_q};
            else
                rd_data <= '0;
        end
    end

    a_r6_accept_loads_cppr: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_data[15:14] == EXC_PHYS) |-> cppr_q == rd_data[7:0]);
    a_r7_idle_accept_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !present) |=> $stable(cppr_q));
    a_r3_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend != '0);
    a_r9_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(is_rd));
    a_r5_type_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[15:14] == EXC_NONE || rd_data[15:14] == EXC_PHYS));
endmodule

// File: tb/thread_irq_presenter_bench.sv
module thread_irq_presenter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [2:0]  ev_prio = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thread_irq_presenter u_thread_irq_presenter (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_prio(ev_prio),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [11:0] a, input logic [7:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; wr_data = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic reg_rd(input logic [11:0] a, output logic [15:0] d, output logic v);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data; v = rd_valid;
    endtask

    task automatic notify(input logic [2:0] p);
        ev_valid = 1'b1; ev_prio = p;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    function automatic int lowest(input logic [7:0] m);
        for (int i = 7; i >= 0; i--) if (m[i]) lowest = i;
        if (m == 0) lowest = 8;
    endfunction

    // Empties every pending level by raising the threshold and accepting.
    task automatic drain();
        logic [15:0] d; logic v; int n;
        n = 0;
        do begin
            reg_wr(12'h031, 8'hFF);
            reg_rd(12'h830, d, v);
            n++;
        end while (d[15:14] != 2'b00 && n < 12);
        chk("R7 drain ends with type 00", 32'(n <= 9), 32'd1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=finish", WATCHDOG);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d; logic v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq low after reset", 32'(irq), 32'd0);
        chk("R1 rd_valid low after reset", 32'(rd_valid), 32'd0);
        reg_rd(12'h031, d, v);
        chk("R1 threshold reset value", 32'(d), 32'h0000);
        chk("R9 rd_valid with read", 32'(v), 32'd1);
        reg_wr(12'h031, 8'hFF);
        chk("R1 nothing pending after reset", 32'(irq), 32'd0);

        // Exhaustive sweep: all pending patterns against thresholds 0..8 and 0xFF.
        for (int m = 0; m < 256; m++) begin
            for (int ci = 0; ci < 10; ci++) begin
                logic [7:0] c;
                int lo, expirq;
                c = (ci == 9) ? 8'hFF : 8'(ci);
                drain();
                for (int b = 0; b < 8; b++) if (m[b]) notify(3'(b));
                reg_wr(12'h031, c);
                lo = lowest(8'(m));
                expirq = (lo < 8 && lo < int'(c)) ? 1 : 0;
                chk("R3 irq against threshold", 32'(irq), 32'(expirq));
                reg_rd(12'h031, d, v);
                chk("R4 threshold readback", 32'(d), {24'h0, c});
                reg_rd(12'h830, d, v);
                chk("R9 accept rd_valid", 32'(v), 32'd1);
                if (expirq == 1) begin
                    logic [7:0] rest;
                    chk("R5 accept word", 32'(d), 32'h8000 | 32'(lo));
                    rest = 8'(m) & ~(8'd1 << lo);
                    chk("R6 irq after accept", 32'(irq), 32'((lowest(rest) < lo) ? 1 : 0));
                    reg_rd(12'h031, d, v);
                    chk("R6 threshold loaded", 32'(d), 32'(lo));
                    if (rest != 0) begin
                        reg_wr(12'h031, 8'hFF);
                        reg_rd(12'h830, d, v);
                        chk("R6 next accept skips cleared level", 32'(d), 32'h8000 | 32'(lowest(rest)));
                    end
                end else begin
                    chk("R7 idle accept word", 32'(d), {24'h0, c});
                    reg_rd(12'h031, d, v);
                    chk("R7 threshold unchanged", 32'(d), {24'h0, c});
                    chk("R7 irq unchanged", 32'(irq), 32'd0);
                end
            end
        end

        // R8: notification of the same level during its acceptance.
        drain();
        notify(3'd4);
        reg_wr(12'h031, 8'hFF);
        ev_valid = 1'b1; ev_prio = 3'd4;
        reg_rd(12'h830, d, v);
        ev_valid = 1'b0;
        chk("R8 accept returns level 4", 32'(d), 32'h8004);
        reg_wr(12'h031, 8'hFF);
        chk("R8 same level still pending", 32'(irq), 32'd1);
        reg_rd(12'h830, d, v);
        chk("R8 re-accept level 4", 32'(d), 32'h8004);

        // R8: a different level arriving during acceptance.
        drain();
        notify(3'd5);
        reg_wr(12'h031, 8'hFF);
        ev_valid = 1'b1; ev_prio = 3'd2;
        reg_rd(12'h830, d, v);
        ev_valid = 1'b0;
        chk("R8 accept returns level 5", 32'(d), 32'h8005);
        chk("R8 level 2 beats new threshold 5", 32'(irq), 32'd1);
        reg_rd(12'h830, d, v);
        chk("R8 accept level 2", 32'(d), 32'h8002);

        // R9: other offsets read zero, stray writes ignored.
        drain();
        reg_wr(12'h031, 8'h06);
        reg_rd(12'h100, d, v);
        chk("R9 other offset reads 0", 32'(d), 32'h0);
        reg_wr(12'h830, 8'h01);
        reg_wr(12'h032, 8'h02);
        reg_rd(12'h031, d, v);
        chk("R9 stray writes ignored", 32'(d), 32'h0006);
        @(negedge clk);
        chk("R9 rd_valid drops without read", 32'(rd_valid), 32'd0);

        // R2: accumulation of several notifications, accepted in urgency order.
        notify(3'd7); notify(3'd3); notify(3'd0);
        reg_wr(12'h031, 8'hFF);
        reg_rd(12'h830, d, v);
        chk("R2 first accept level 0", 32'(d), 32'h8000);
        reg_wr(12'h031, 8'hFF);
        reg_rd(12'h830, d, v);
        chk("R2 second accept level 3", 32'(d), 32'h8003);
        reg_wr(12'h031, 8'hFF);
        reg_rd(12'h830, d, v);
        chk("R2 third accept level 7", 32'(d), 32'h8007);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule